// File: doc/BRIEF.md
# Synchronous Byte FIFO Link Device Emulator

This block stands in for the bridge-chip end of an 8-bit synchronous parallel FIFO link, so that an FPGA-side controller can be exercised against a realistic partner. It forwards its clock as the link clock and shares one bidirectional byte bus with the controller. It raises an active-low "byte waiting" flag and an active-low "room to write" flag, and it answers active-low read, write, output-enable and wake-up strobes from the controller. The emulator does all of its sampling and updating on the falling clock edge, half a period away from a rising-edge controller.

Bytes that would come from the host are preloaded into a receive queue through a load port. Bytes the controller writes are kept in a transmit queue and drained through a readback port. Each flag is produced by a small state machine with three states. FLAG_IDLE holds the flag deasserted. FLAG_LIVE holds it asserted. FLAG_HOLD keeps it asserted for the one settling cycle after a byte has been accepted. The transitions are as follows. IDLE→LIVE when the queue can serve. LIVE→HOLD on an accepted strobe. LIVE→IDLE when the queue can no longer serve. HOLD→LIVE or HOLD→IDLE depending on the queue state. Protocol misuse, bus fights and wake-up requests are recorded for the test environment.

Top module: `usb_fifo_bridge_model`

## Requirements
- R1: A synchronous active-high `rst` empties both queues. It drives `rx_avail_n` and `tx_space_n` high, clears `err_proto`, `contention` and `wake_count`, shows `ld_ready`=1 and shows `tx_has`=0.
- R2: While `oe_n` is 0 the emulator drives `data_io` with the oldest receive byte, or 0x00 when the receive queue is empty. While `oe_n` is 1 it leaves the bus undriven, so a value the controller drives is seen unchanged.
- R3: After every falling edge, `rx_avail_n` is 0 exactly when the receive queue held at least one byte just before that edge. The flag therefore lags a read or a load by one cycle.
- R4: After every falling edge, `tx_space_n` is 0 exactly when the transmit queue held fewer than DEPTH bytes just before that edge.
- R5: `rd_n`=0 at a falling edge with a non-empty receive queue removes the oldest byte. Bytes leave in the order they were loaded.
- R6: `wr_n`=0 with `oe_n`=1 at a falling edge with fewer than DEPTH bytes queued captures `data_io` into the transmit queue. `tx_has`=1 whenever it is non-empty, and `tx_byte` shows its oldest byte. `tx_pop`=1 at a falling edge removes that byte.
- R7: `ld_en`=1 at a falling edge appends `ld_byte` when the receive queue held fewer than DEPTH bytes. Otherwise the request is ignored. `ld_ready` is 1 exactly when the queue is not full.
- R8: A read strobe on an empty receive queue, or a write strobe (with `oe_n`=1) on a full transmit queue, changes no queue and sets `err_proto`. That flag stays set until reset.
- R9: `oe_n`=0 and `wr_n`=0 at the same falling edge set a sticky `contention` flag, and no byte is captured.
- R10: Each high-to-low change of `wake_n`, seen at a falling edge, adds one to `wake_count`, which wraps at 2^WAKE_W. Holding `wake_n` low counts once.
- R11: `if_clk` follows `clk`, and all emulator state changes on the falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, forwarded as the link clock |
| rst | input | 1 | Synchronous active-high reset |
| if_clk | output | 1 | Link clock seen by the controller |
| data_io | inout | BYTE_W | Shared byte bus |
| rx_avail_n | output | 1 | Low: a byte is waiting to be read |
| tx_space_n | output | 1 | Low: a byte can be written |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low request for the emulator to drive the bus |
| wake_n | input | 1 | Active-low wake-up request |
| ld_en | input | 1 | Load `ld_byte` into the receive queue |
| ld_byte | input | BYTE_W | Byte to load |
| ld_ready | output | 1 | Receive queue has room |
| tx_pop | input | 1 | Remove the oldest captured byte |
| tx_byte | output | BYTE_W | Oldest captured byte |
| tx_has | output | 1 | Transmit queue is non-empty |
| err_proto | output | 1 | Sticky protocol-misuse flag |
| contention | output | 1 | Sticky bus-fight flag |
| wake_count | output | WAKE_W | Number of wake-up requests |

## Verification
The bench builds the emulator with DEPTH=4 and WAKE_W=3. The shallow queues reach full, empty and pointer wrap-around many times in a few thousand cycles, which exercises the full-queue flag lag and the refused-load case. The 3-bit wake counter wraps after eight requests, so its modular behaviour is checked with a short directed burst.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
    typedef enum logic [1:0] {
        FLAG_IDLE = 2'd0,
        FLAG_LIVE = 2'd1,
        FLAG_HOLD = 2'd2
    } flag_st_e;
endpackage

// File: rtl/bfe_queue.sv
module bfe_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Pointers and occupancy move on the falling edge.
    always_ff @(negedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(negedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/bfe_flag_fsm.sv
module bfe_flag_fsm
    import bfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic avail,     // queue can serve, before this edge's update
    input  logic consume,   // strobe accepted at this edge
    output logic flag_n
);
    flag_st_e state, state_nx;

    always_ff @(negedge clk) begin
        if (rst) state <= FLAG_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_IDLE: if (avail) state_nx = FLAG_LIVE;
            FLAG_LIVE: begin
                if (consume)     state_nx = FLAG_HOLD;
                else if (!avail) state_nx = FLAG_IDLE;
            end
            FLAG_HOLD: state_nx = avail ? FLAG_LIVE : FLAG_IDLE;
            default:   state_nx = FLAG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            FLAG_LIVE, FLAG_HOLD: flag_n = 1'b0;
            default:              flag_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/usb_fifo_bridge_model.sv
module usb_fifo_bridge_model #(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8,
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              if_clk,
    inout  wire  [BYTE_W-1:0] data_io,
    output logic              rx_avail_n,
    output logic              tx_space_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              wake_n,
    input  logic              ld_en,
    input  logic [BYTE_W-1:0] ld_byte,
    output logic              ld_ready,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_has,
    output logic              err_proto,
    output logic              contention,
    output logic [WAKE_W-1:0] wake_count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] rx_head, bus_out;
    logic [CNT_W-1:0]  rx_cnt, tx_cnt;
    logic              rx_empty, rx_full, tx_empty, tx_full;
    logic              rd_ok, wr_ok, ld_ok, pop_ok;
    logic              rd_bad, wr_bad, fight;
    logic              wake_q;

    assign if_clk = clk;

    // Strobe qualification against queue state before the edge
    assign rd_ok  = !rd_n && !rx_empty;
    assign rd_bad = !rd_n && rx_empty;
    assign fight  = !wr_n && !oe_n;
    assign wr_ok  = !wr_n && oe_n && !tx_full;
    assign wr_bad = !wr_n && oe_n && tx_full;
    assign ld_ok  = ld_en && !rx_full;
    assign pop_ok = tx_pop && !tx_empty;

    bfe_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
        .clk(clk), .rst(rst),
        .push(ld_ok), .push_data(ld_byte),
        .pop(rd_ok), .head(rx_head),
        .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    bfe_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
        .clk(clk), .rst(rst),
        .push(wr_ok), .push_data(data_io),
        .pop(pop_ok), .head(tx_byte),
        .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    bfe_flag_fsm u_rxflag (
        .clk(clk), .rst(rst),
        .avail(!rx_empty), .consume(rd_ok),
        .flag_n(rx_avail_n)
    );

    bfe_flag_fsm u_txflag (
        .clk(clk), .rst(rst),
        .avail(!tx_full), .consume(wr_ok),
        .flag_n(tx_space_n)
    );

    // Bus direction follows the output enable
    assign bus_out = rx_empty ? '0 : rx_head;
    assign data_io = oe_n ? {BYTE_W{1'bz}} : bus_out;

    assign ld_ready = !rx_full;
    assign tx_has   = !tx_empty;

    always_ff @(negedge clk) begin
        if (rst) begin
            err_proto  <= 1'b0;
            contention <= 1'b0;
            wake_q     <= 1'b1;
            wake_count <= '0;
        end else begin
            if (rd_bad || wr_bad) err_proto  <= 1'b1;
            if (fight)            contention <= 1'b1;
            wake_q <= wake_n;
            if (wake_q && !wake_n) wake_count <= wake_count + WAKE_W'(1);
        end
    end
endmodule

// File: rtl/bfe_checker.sv
module bfe_checker #(
    parameter int DEPTH  = 16,
    parameter int WAKE_W = 8,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_n,
    input logic              wr_n,
    input logic              oe_n,
    input logic              wake_n,
    input logic              tx_pop,
    input logic              rx_avail_n,
    input logic              tx_space_n,
    input logic              err_proto,
    input logic              contention,
    input logic [WAKE_W-1:0] wake_count,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [CNT_W-1:0]  tx_cnt
);
    logic armed = 1'b0;
    always_ff @(negedge clk) armed <= !rst;

    // R1
    reset_state_chk: assert property (@(negedge clk) disable iff (rst)
        $past(rst) |-> (rx_avail_n && tx_space_n && !err_proto && !contention && wake_count == '0));

    // R3
    rx_flag_lag_chk: assert property (@(negedge clk) disable iff (rst || !armed)
        rx_avail_n == ($past(rx_cnt) == '0));

    // R4
    tx_flag_lag_chk: assert property (@(negedge clk) disable iff (rst || !armed)
        tx_space_n == ($past(tx_cnt) == CNT_W'(DEPTH)));

    // R8
    err_sticky_chk: assert property (@(negedge clk) disable iff (rst)
        err_proto |=> err_proto);

    // R8
    underflow_flag_chk: assert property (@(negedge clk) disable iff (rst)
        (!rd_n && rx_cnt == '0) |=> (err_proto && rx_cnt == '0) || $past(rx_cnt) != rx_cnt);

    // R9
    fight_flag_chk: assert property (@(negedge clk) disable iff (rst)
        (!oe_n && !wr_n) |=> contention);

    // R9
    fight_no_capture_chk: assert property (@(negedge clk) disable iff (rst)
        (!oe_n && !tx_pop) |=> $stable(tx_cnt));

    // R10
    wake_step_chk: assert property (@(negedge clk) disable iff (rst || !armed)
        $fell(wake_n) |=> wake_count == WAKE_W'($past(wake_count) + 1'b1));

    // R10
    wake_hold_chk: assert property (@(negedge clk) disable iff (rst || !armed)
        !$fell(wake_n) |=> $stable(wake_count));
endmodule

bind usb_fifo_bridge_model bfe_checker #(
    .DEPTH(DEPTH), .WAKE_W(WAKE_W), .CNT_W(CNT_W)
) u_bfe_chk (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n),
    .wake_n(wake_n), .tx_pop(tx_pop), .rx_avail_n(rx_avail_n),
    .tx_space_n(tx_space_n), .err_proto(err_proto), .contention(contention),
    .wake_count(wake_count), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/tb_usb_fifo_bridge_model.sv
module tb_usb_fifo_bridge_model;
    localparam int DEP = 4;
    localparam int WW  = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1, rd_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1, wake_n = 1'b1;
    logic       ld_en = 1'b0, tx_pop = 1'b0;
    logic [7:0] ld_byte = '0, tb_dat = '0;
    wire  [7:0] data_io;
    logic       if_clk, rx_avail_n, tx_space_n, ld_ready, tx_has, err_proto, contention;
    logic [7:0] tx_byte;
    logic [WW-1:0] wake_count;

    assign data_io = oe_n ? tb_dat : 8'bz;

    usb_fifo_bridge_model #(.DEPTH(DEP), .BYTE_W(8), .WAKE_W(WW)) dut (
        .clk(clk), .rst(rst), .if_clk(if_clk), .data_io(data_io),
        .rx_avail_n(rx_avail_n), .tx_space_n(tx_space_n),
        .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n), .wake_n(wake_n),
        .ld_en(ld_en), .ld_byte(ld_byte), .ld_ready(ld_ready),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_has(tx_has),
        .err_proto(err_proto), .contention(contention), .wake_count(wake_count)
    );

    int total = 0, bad = 0;
    byte unsigned rxm[$], txm[$];
    bit  e_rxn = 1, e_txn = 1, e_err = 0, e_cont = 0, wprev = 1;
    int  e_wake = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R11 if_clk", int'(if_clk), 1);
        chk("R3 rx_avail_n", int'(rx_avail_n), int'(e_rxn));
        chk("R4 tx_space_n", int'(tx_space_n), int'(e_txn));
        chk("R7 ld_ready", int'(ld_ready), int'(rxm.size() < DEP));
        chk("R6 tx_has", int'(tx_has), int'(txm.size() > 0));
        if (txm.size() > 0) chk("R6 tx_byte", int'(tx_byte), int'(txm[0]));
        if (!oe_n) chk("R2,R5 bus", int'(data_io), rxm.size() > 0 ? int'(rxm[0]) : 0);
        chk("R8 err_proto", int'(err_proto), int'(e_err));
        chk("R9 contention", int'(contention), int'(e_cont));
        chk("R10 wake_count", int'(wake_count), e_wake);
    endtask

    // Reference model update at the emulator's sampling edge, then check mid-cycle
    task automatic tick();
        @(negedge clk);
        if (rst) begin
            rxm.delete(); txm.delete();
            e_rxn = 1; e_txn = 1; e_err = 0; e_cont = 0; e_wake = 0; wprev = 1;
        end else begin
            int rpre = rxm.size();
            int tpre = txm.size();
            e_rxn = (rpre == 0);
            e_txn = (tpre == DEP);
            if (!rd_n) begin
                if (rpre > 0) void'(rxm.pop_front());
                else e_err = 1;
            end
            if (ld_en && rpre < DEP) rxm.push_back(ld_byte);
            if (!wr_n) begin
                if (!oe_n) e_cont = 1;
                else if (tpre < DEP) txm.push_back(tb_dat);
                else e_err = 1;
            end
            if (tx_pop && tpre > 0) void'(txm.pop_front());
            if (wprev && !wake_n) e_wake = (e_wake + 1) % (1 << WW);
            wprev = wake_n;
        end
        @(posedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        rd_n = 1; wr_n = 1; ld_en = 0; tx_pop = 0;
    endtask

    task automatic do_reset();
        idle_inputs(); oe_n = 1; wake_n = 1; rst = 1;
        tick(); tick();
        // R1: reset state at the ports
        chk("R1 rx_avail_n", int'(rx_avail_n), 1);
        chk("R1 tx_space_n", int'(tx_space_n), 1);
        chk("R1 ld_ready", int'(ld_ready), 1);
        chk("R1 tx_has", int'(tx_has), 0);
        chk("R1 err", int'(err_proto), 0);
        chk("R1 cont", int'(contention), 0);
        chk("R1 wake", int'(wake_count), 0);
        rst = 0;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0bfe));
        @(posedge clk);
        do_reset();

        // R7/R3/R5: load more than DEP bytes, extra load refused
        oe_n = 0;
        for (int i = 0; i < DEP + 2; i++) begin
            ld_en = 1; ld_byte = 8'hA0 + 8'(i); tick();
        end
        ld_en = 0; tick();
        // R5: paced reads, one strobe then a settle cycle
        for (int i = 0; i < DEP; i++) begin
            rd_n = 0; tick(); rd_n = 1; tick();
        end

        // R6/R4: fill the transmit queue, then drain
        oe_n = 1;
        for (int i = 0; i < DEP; i++) begin
            wr_n = 0; tb_dat = 8'h30 + 8'(i); tick();
        end
        wr_n = 1; tick(); tick();
        for (int i = 0; i < DEP; i++) begin
            tx_pop = 1; tick();
        end
        tx_pop = 0; tick();

        // R8: write on full queue
        for (int i = 0; i <= DEP; i++) begin
            wr_n = 0; tb_dat = 8'h50 + 8'(i); tick();
        end
        wr_n = 1; tick();
        do_reset();

        // R8: read on empty queue
        rd_n = 0; tick(); rd_n = 1; tick();
        do_reset();

        // R9: bus fight, byte not captured
        oe_n = 0; wr_n = 0; tick(); wr_n = 1; tick();
        oe_n = 1; tick();
        do_reset();

        // R10: nine short requests wrap the counter, then one long hold
        for (int i = 0; i < 9; i++) begin
            wake_n = 0; tick(); wake_n = 1; tick();
        end
        wake_n = 0;
        for (int i = 0; i < 5; i++) tick();
        wake_n = 1; tick();
        do_reset();

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            oe_n    = 1'($urandom % 2);
            rd_n    = !(rxm.size() > 0 && ($urandom % 2 == 1));
            wr_n    = !(oe_n && txm.size() < DEP && ($urandom % 2 == 1));
            ld_en   = 1'($urandom % 2);
            ld_byte = 8'($urandom);
            tb_dat  = 8'($urandom);
            tx_pop  = ($urandom % 3 == 0);
            if ($urandom % 8 == 0) wake_n = !wake_n;
            tick();
        end
        idle_inputs(); tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule